// File: doc/BRIEF.md
# Pseudo-Random Link Bit Error Injector

This block sits on the transmit side of a four-lane serial link, after the characters have been encoded and before they are serialized. It deliberately corrupts outgoing traffic so that a far-end receiver's error detection and recovery paths can be tested. Software programs a single 32-bit configuration word that holds an injection mode and a delay range.

While a legal non-zero mode is programmed and the range is non-zero, the block draws a pseudo-random delay between one and range×32 character times. It counts down that delay on the character-valid strobe. When the delay runs out, it inverts a single bit of the 10-bit character on one lane, on every lane, or on a lane picked at random. Then it draws a fresh delay.

Every lane passes through one register stage whether or not it is corrupted, so the latency is the same on all lanes.

Top module: `link_err_inject`

## Requirements
- R1: With mode code 00000 in bits 31:27 of the configuration word, every output character equals its input character.
- R2: Mode 10000 corrupts only lane 0, 01000 only lane 1, 00100 only lane 2 and 00010 only lane 3. Lane n occupies bits [10n+9:10n] of the data buses.
- R3: Mode 11110 corrupts all four lanes in the same character time, and never a subset of them.
- R4: An injection inverts exactly one bit of each affected lane's character, leaving the other nine unchanged. Under mode 11111 each injection touches exactly one lane, and more than one lane gets hit across a run.
- R5: Valid characters are counted from a configuration write, or from the previous corrupted character. The next corrupted character arrives at a count between 1 and range×32, where range is bits 19:0 of the configuration word.
- R6: The configuration word reads back with the mode in bits 31:27, bits 26:20 as zero, and the range in bits 19:0. It reads as zero after reset.
- R7: Mode codes other than 00000, 10000, 01000, 00100, 00010, 11110 and 11111 inject nothing.
- R8: A range of zero injects nothing, whatever the mode.
- R9: A configuration write restarts the delay countdown. A character presented in the same cycle as a write leaves the block unchanged.
- R10: The output valid follows the input valid exactly one clock later, and uncorrupted characters come out unchanged after that single register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word, reserved bits zero |
| char_vld | input | 1 | One character time: tx_in carries a character on every lane |
| tx_in | input | 40 | Encoded characters, four lanes of 10 bits |
| tx_out_vld | output | 1 | Registered copy of char_vld |
| tx_out | output | 40 | Characters after optional bit inversion |

## Verification
The two functions that can land in one cycle are a configuration write and a character strobe that the countdown would otherwise spend or fire on. Every test phase begins with a write that carries a valid character. One phase keeps re-writing the same configuration every fifth character under dense all-lane injection, so restarts collide with live traffic and with pending expiries. The scoreboard treats the character that accompanies a write as one that must come out untouched. It also resets its own gap count at that point, so a countdown that is not restarted shows up as a range violation later.

// File: rtl/lei_pkg.sv
package lei_pkg;

    localparam int CFG_W      = 32;
    localparam int MODE_W     = 5;
    localparam int MODE_LSB   = 27;
    localparam int NUM_LANES  = 4;
    localparam int LANE_IDX_W = 2;

    typedef enum logic [1:0] {
        INJ_OFF,
        INJ_FIXED,
        INJ_ALL,
        INJ_RAND
    } inj_kind_e;

    typedef struct packed {
        inj_kind_e               kind;
        logic [LANE_IDX_W-1:0]   lane;
    } inj_sel_t;

    // Unlisted codes fall through to INJ_OFF.
    function automatic inj_sel_t decode_mode(input logic [MODE_W-1:0] code);
        inj_sel_t s;
        s.kind = INJ_OFF;
        s.lane = '0;
        case (code)
            5'b10000: begin s.kind = INJ_FIXED; s.lane = 2'd0; end
            5'b01000: begin s.kind = INJ_FIXED; s.lane = 2'd1; end
            5'b00100: begin s.kind = INJ_FIXED; s.lane = 2'd2; end
            5'b00010: begin s.kind = INJ_FIXED; s.lane = 2'd3; end
            5'b11110: s.kind = INJ_ALL;
            5'b11111: s.kind = INJ_RAND;
            default:  s.kind = INJ_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lei_lfsr.sv
module lei_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'h0000_0001
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd
);

    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_t;

    lfsr_t st_d, st_q;

    // Galois form, one shift per clock, never reaches all-zero.
    always_comb begin
        st_d.sr = {1'b0, st_q.sr[W-1:1]} ^ (st_q.sr[0] ? POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sr: SEED};
        else        st_q <= st_d;
    end

    assign rnd = st_q.sr;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sr != '0); // R5

endmodule

// File: rtl/lei_countdown.sv
module lei_countdown #(
    parameter int CNT_W = 25,
    parameter int RND_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             enable,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    input  logic [RND_W-1:0] rnd,
    output logic             fire
);

    localparam int PROD_W = CNT_W + RND_W;

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } cd_t;

    cd_t              st_d, st_q;
    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  new_delay;

    always_comb begin
        // Scale a RND_W-bit fraction by the limit: result lies in 0..limit-1.
        prod      = {{CNT_W{1'b0}}, rnd} * {{RND_W{1'b0}}, limit};
        new_delay = prod[RND_W +: CNT_W] + CNT_W'(1);
        st_d      = st_q;
        fire      = 1'b0;
        if (restart) begin
            st_d.armed = enable && (limit != '0);
            st_d.cnt   = new_delay;
        end else if (st_q.armed && step) begin
            if (st_q.cnt == CNT_W'(1)) begin
                fire     = 1'b1;
                st_d.cnt = new_delay;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !restart) |-> (st_q.cnt != '0 && st_q.cnt <= limit)); // R5

endmodule

// File: rtl/lei_flipper.sv
module lei_flipper
    import lei_pkg::*;
#(
    parameter int LANES  = NUM_LANES,
    parameter int CHAR_W = 10,
    localparam int DATA_W = LANES * CHAR_W,
    localparam int POS_W  = $clog2(CHAR_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vld_i,
    input  logic [DATA_W-1:0]     din,
    input  logic                  fire,
    input  inj_sel_t              sel,
    input  logic [POS_W-1:0]      bit_pos,
    input  logic [LANE_IDX_W-1:0] rnd_lane,
    output logic                  vld_o,
    output logic [DATA_W-1:0]     dout
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } fl_t;

    fl_t               st_d, st_q;
    logic [DATA_W-1:0] mask;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        logic hit;
        always_comb begin
            hit = fire && ((sel.kind == INJ_ALL)
                        || (sel.kind == INJ_FIXED && sel.lane == LANE_IDX_W'(gi))
                        || (sel.kind == INJ_RAND  && rnd_lane == LANE_IDX_W'(gi)));
        end
        assign mask[gi*CHAR_W +: CHAR_W] = hit ? (CHAR_W'(1) << bit_pos) : '0;

        AST_ONE_BIT_PER_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |=> ($countones(st_q.data[gi*CHAR_W +: CHAR_W]
                                  ^ $past(din[gi*CHAR_W +: CHAR_W])) <= 1)); // R4
        AST_ALL_LANES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && sel.kind == INJ_ALL)
            |=> (st_q.data[gi*CHAR_W +: CHAR_W] != $past(din[gi*CHAR_W +: CHAR_W]))); // R3
    end

    always_comb begin
        st_d.vld  = vld_i;
        st_d.data = vld_i ? (din ^ mask) : st_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign dout  = st_q.data;

    AST_RAND_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.kind == INJ_RAND) |-> $onehot0(mask)); // R4

endmodule

// File: rtl/link_err_inject.sv
module link_err_inject
    import lei_pkg::*;
#(
    parameter int CHAR_W    = 10,
    parameter int RANGE_W   = 20,
    parameter int SCALE_SH  = 5,
    parameter int LFSR_W    = 32,
    parameter int DLY_RND_W = 16,
    parameter int POS_RND_W = 4,
    localparam int LANES    = NUM_LANES,
    localparam int DATA_W   = LANES * CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              char_vld,
    input  logic [DATA_W-1:0] tx_in,
    output logic              tx_out_vld,
    output logic [DATA_W-1:0] tx_out
);

    localparam int CNT_W      = RANGE_W + SCALE_SH;
    localparam int POS_W      = $clog2(CHAR_W);
    localparam int POS_PROD_W = POS_RND_W + POS_W;
    localparam int RSVD_W     = CFG_W - MODE_W - RANGE_W;
    localparam int LANE_MSB   = LFSR_W - 1;
    localparam int POS_MSB    = LFSR_W - LANE_IDX_W - 1;

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [RANGE_W-1:0] rng;
    } cfg_t;

    cfg_t                  cfg_d, cfg_q;
    inj_sel_t              sel_nxt, sel_cur;
    logic [CNT_W-1:0]      limit;
    logic [LFSR_W-1:0]     rnd;
    logic                  fire;
    logic [POS_PROD_W-1:0] pos_prod;
    logic [POS_W-1:0]      bit_pos;

    // Configuration register: the next value feeds the countdown so that a
    // write reloads with the freshly written range.
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.mode = cfg_wdata[MODE_LSB +: MODE_W];
            cfg_d.rng  = cfg_wdata[RANGE_W-1:0];
        end
        sel_nxt  = decode_mode(cfg_d.mode);
        sel_cur  = decode_mode(cfg_q.mode);
        limit    = {cfg_d.rng, {SCALE_SH{1'b0}}};
        pos_prod = {{POS_W{1'b0}}, rnd[POS_MSB -: POS_RND_W]} * POS_PROD_W'(CHAR_W);
        bit_pos  = pos_prod[POS_RND_W +: POS_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_rdata = {cfg_q.mode, {RSVD_W{1'b0}}, cfg_q.rng};

    lei_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    lei_countdown #(.CNT_W(CNT_W), .RND_W(DLY_RND_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_we),
        .enable  (sel_nxt.kind != INJ_OFF),
        .step    (char_vld),
        .limit   (limit),
        .rnd     (rnd[DLY_RND_W-1:0]),
        .fire    (fire)
    );

    lei_flipper #(.LANES(LANES), .CHAR_W(CHAR_W)) u_flip (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (char_vld),
        .din      (tx_in),
        .fire     (fire),
        .sel      (sel_cur),
        .bit_pos  (bit_pos),
        .rnd_lane (rnd[LANE_MSB -: LANE_IDX_W]),
        .vld_o    (tx_out_vld),
        .dout     (tx_out)
    );

    AST_MODE_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && cfg_q.mode == '0) |-> !fire); // R1
    AST_RSVD_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && sel_cur.kind == INJ_OFF) |-> !fire); // R7
    AST_ZERO_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && cfg_q.rng == '0) |-> !fire); // R8
    AST_WRITE_CHAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && char_vld) |=> (tx_out == $past(tx_in))); // R9
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld |=> tx_out_vld); // R10
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !char_vld |=> !tx_out_vld); // R10
    AST_POS_IN_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos < POS_W'(CHAR_W)); // R4

endmodule

// File: tb/sim_link_err_inject.sv
`timescale 1ns/1ps
module sim_link_err_inject;

    localparam int CW = 10;
    localparam int NL = 4;
    localparam int DW = CW * NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          char_vld = 1'b0;
    logic [DW-1:0] tx_in = '0;
    logic          tx_out_vld;
    logic [DW-1:0] tx_out;

    always #2 clk = ~clk;

    link_err_inject u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .char_vld(char_vld), .tx_in(tx_in),
        .tx_out_vld(tx_out_vld), .tx_out(tx_out)
    );

    typedef struct {
        logic          vld;
        logic [DW-1:0] data;
        logic          restart;
        logic [4:0]    mode;
        logic [19:0]   rng;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [4:0]  cur_mode = '0;
    logic [19:0] cur_rng = '0;
    int          nvld = 0;
    int          inj_cnt = 0;
    logic [3:0]  lane_seen = '0;
    int          gap = 0;
    logic [31:0] lcg = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench view of the mode codes: 0 off, 1 fixed lane, 2 all lanes, 3 random lane.
    function automatic int kind_of(input logic [4:0] m);
        case (m)
            5'b10000, 5'b01000, 5'b00100, 5'b00010: return 1;
            5'b11110: return 2;
            5'b11111: return 3;
            default:  return 0;
        endcase
    endfunction

    function automatic int lane_of(input logic [4:0] m);
        case (m)
            5'b10000: return 0;
            5'b01000: return 1;
            5'b00100: return 2;
            default:  return 3;
        endcase
    endfunction

    function automatic logic [DW-1:0] next_data();
        logic [63:0] w;
        lcg = lcg * 32'd1103515245 + 32'd12345;
        w[31:0] = lcg;
        lcg = lcg * 32'd1103515245 + 32'd12345;
        w[63:32] = lcg;
        return w[DW-1:0];
    endfunction

    // Driver: one call per clock, pushes what the output must reflect.
    task automatic cyc(input logic v, input logic [DW-1:0] d, input logic we, input logic [31:0] wd);
        item_t it;
        @(negedge clk);
        char_vld  = v;
        tx_in     = d;
        cfg_we    = we;
        cfg_wdata = wd;
        if (we) begin
            cur_mode = wd[31:27];
            cur_rng  = wd[19:0];
        end
        it.vld = v; it.data = d; it.restart = we; it.mode = cur_mode; it.rng = cur_rng;
        sb.push_back(it);
        if (v) nvld++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, '0);
    endtask

    task automatic phase(input logic [4:0] m, input logic [19:0] r, input int nchar, input int wr_every);
        logic [31:0] w;
        w = {m, 7'b0, r};
        cyc(1'b1, next_data(), 1'b1, w);   // write collides with a character
        idle(2);
        inj_cnt = 0; lane_seen = '0; nvld = 0;
        for (int k = 0; k < nchar; k++) begin
            logic v, we;
            v  = (k % 7) != 6;
            we = v && (wr_every > 0) && ((k % wr_every) == wr_every - 1);
            cyc(v, v ? next_data() : '0, we, w);
        end
        idle(3);
    endtask

    // Monitor / scoreboard
    always begin
        item_t it;
        @(posedge clk);
        #1;
        if (rst_n && sb.size() > 0) begin
            it = sb.pop_front();
            chk(tx_out_vld == it.vld, "R10 output valid one clock after input", tx_out_vld, it.vld);
            if (it.restart) gap = 0;
            if (it.vld) begin
                int         nhit;
                logic [3:0] hitv;
                int         k;
                bit         active;
                longint     lim;
                nhit = 0; hitv = '0;
                for (int l = 0; l < NL; l++) begin
                    logic [CW-1:0] diff;
                    diff = tx_out[l*CW +: CW] ^ it.data[l*CW +: CW];
                    if (diff != '0) begin
                        hitv[l] = 1'b1;
                        nhit++;
                        chk($countones(diff) == 1, "R4 exactly one bit per hit lane", $countones(diff), 1);
                    end
                end
                k = kind_of(it.mode);
                active = !it.restart && k != 0 && it.rng != '0;
                lim = longint'(it.rng) * 32;
                if (!active) begin
                    if (it.restart)        chk(nhit == 0, "R9 character with write unchanged", tx_out, it.data);
                    else if (it.mode == 0) chk(nhit == 0, "R1 mode zero passes data", tx_out, it.data);
                    else if (it.rng == 0)  chk(nhit == 0, "R8 zero range passes data", tx_out, it.data);
                    else                   chk(nhit == 0, "R7 reserved mode passes data", tx_out, it.data);
                end else begin
                    if (k == 1)
                        chk((hitv & ~(4'b1 << lane_of(it.mode))) == 0, "R2 only selected lane",
                            hitv, 4'b1 << lane_of(it.mode));
                    else if (k == 2)
                        chk(nhit == 0 || nhit == 4, "R3 all lanes together", hitv, 4'hF);
                    else
                        chk(nhit <= 1, "R4 random mode one lane", nhit, 1);
                    gap++;
                    if (nhit > 0) begin
                        chk(gap <= lim, "R5 gap within range", gap, lim);
                        gap = 0;
                        inj_cnt++;
                        lane_seen |= hitv;
                    end else begin
                        chk(gap < lim, "R5 gap within range", gap, lim);
                    end
                end
            end
        end
    end

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        chk(cfg_rdata == 32'h0, "R6 reset config reads zero", cfg_rdata, 0);
        chk(tx_out_vld == 1'b0, "R10 valid low in reset", tx_out_vld, 0);
        rst_n = 1'b1;

        // R6 register layout and reserved bits
        cyc(1'b0, '0, 1'b1, 32'hFFFF_FFFF);
        idle(1);
        chk(cfg_rdata == 32'hF80F_FFFF, "R6 readback with reserved zero", cfg_rdata, 32'hF80F_FFFF);
        cyc(1'b0, '0, 1'b1, 32'h87F0_0005);
        idle(1);
        chk(cfg_rdata == 32'h8000_0005, "R6 field placement", cfg_rdata, 32'h8000_0005);
        cyc(1'b0, '0, 1'b1, 32'h0);
        idle(1);
        chk(cfg_rdata == 32'h0, "R6 cleared", cfg_rdata, 0);

        // R1 disabled
        phase(5'b00000, 20'd1, 200, 0);
        chk(inj_cnt == 0, "R1 no injections when off", inj_cnt, 0);

        // R2 each fixed lane
        for (int l = 0; l < NL; l++) begin
            phase(5'b10000 >> l, 20'd1, 300, 0);
            v = nvld;
            chk(inj_cnt >= v / 32, "R2 injections occur on fixed lane", inj_cnt, v / 32);
            chk(lane_seen == (4'b1 << l), "R2 lane hit set", lane_seen, 4'b1 << l);
        end

        // R3 all lanes
        phase(5'b11110, 20'd2, 400, 0);
        v = nvld;
        chk(inj_cnt >= v / 64, "R3 injections occur", inj_cnt, v / 64);
        chk(lane_seen == 4'hF, "R3 every lane hit", lane_seen, 4'hF);

        // R4 random lane
        phase(5'b11111, 20'd1, 600, 0);
        v = nvld;
        chk(inj_cnt >= v / 32, "R4 random injections occur", inj_cnt, v / 32);
        chk($countones(lane_seen) >= 2, "R4 random lanes vary", lane_seen, 4'hF);

        // R5 wider range
        phase(5'b00100, 20'd3, 1000, 0);
        v = nvld;
        chk(inj_cnt >= v / 96, "R5 injections within range 96", inj_cnt, v / 96);

        // R7 reserved codes
        phase(5'b11000, 20'd1, 200, 0);
        chk(inj_cnt == 0, "R7 code 11000 quiet", inj_cnt, 0);
        phase(5'b01111, 20'd1, 200, 0);
        chk(inj_cnt == 0, "R7 code 01111 quiet", inj_cnt, 0);
        phase(5'b10001, 20'd1, 200, 0);
        chk(inj_cnt == 0, "R7 code 10001 quiet", inj_cnt, 0);

        // R8 zero range
        phase(5'b10000, 20'd0, 300, 0);
        chk(inj_cnt == 0, "R8 zero range quiet", inj_cnt, 0);

        // R9 repeated restarts under traffic, then disable with a live character
        phase(5'b11110, 20'd1, 300, 5);
        phase(5'b00000, 20'd1, 100, 0);
        chk(inj_cnt == 0, "R9 write to off stops injection", inj_cnt, 0);

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule